// File: doc/BRIEF.md
# Cascadable Counter PWM Generator

This block drives two pulse-width modulated pins, one per channel. Each channel owns a pair of 8-bit up-counters. In single mode only the lower counter runs, and its 256-cycle ramp is compared with the low byte of the channel's compare code. In cascaded mode the lower counter carries into the upper one. The joined count then wraps at a resolution of 10, 12, 14 or 16 bits, and it is compared with the full 16-bit code.

The pin is high while the count is at or below the active code. The comparison result is registered before it reaches the pin, so the pin cannot glitch. The code, the mode and the resolution are sampled only at a period boundary, or at any time while the block is disabled, so a period is never cut short. A code above the largest count of the chosen resolution holds the pin high.

Top module: `cnt_pwm`

## Requirements
- R1: While reset is held, both pins are low and both counters are cleared.
- R2: With the block enabled, a channel's pin is high for the first code+1 cycles of each period and low for the rest of that period.
- R3: Each pin is a registered copy of its comparison. In the cycle after enable is first sampled high, the pin is high, because the count was 0 at that edge.
- R4: In single mode (cascade input 0) the period is 256 cycles, and only code bits 7:0 are compared. Bits 15:8 have no effect.
- R5: In cascaded mode (cascade input 1) the resolution field sets the period to 2^(10+2*field) cycles: 00 gives 10 bits, 01 gives 12, 10 gives 14 and 11 gives 16.
- R6: The two channels run independently. Each has its own cascade input, resolution field and code.
- R7: A code that is equal to or above the largest count of the active resolution keeps the pin high on every cycle.
- R8: A code change made during a period takes effect only at the next counter wrap.
- R9: While enable is low, the counters stay at zero and the pins are low one cycle later. The code, mode and resolution inputs are loaded on every such cycle.
- R10: A change of mode or resolution made while enabled takes effect only at the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable for both channels |
| cas_ab | input | 1 | Channel 0 cascade select |
| cas_cd | input | 1 | Channel 1 cascade select |
| res_ab | input | 2 | Channel 0 cascaded resolution field |
| res_cd | input | 2 | Channel 1 cascaded resolution field |
| code_ab | input | 16 | Channel 0 compare code |
| code_cd | input | 16 | Channel 1 compare code |
| pwm_ab | output | 1 | Channel 0 PWM pin |
| pwm_cd | output | 1 | Channel 1 PWM pin |

## Verification
A wrong carry or wrap point moves the next falling or rising pin edge. The first edge that lands in the wrong place shows the fault within one period of the selected resolution. A code or configuration latched at the wrong moment shows as a high time that is wrong in the period where the change was made, not one period later. A wrong enable or reset path shows on the very next cycle as a pin that is high when it should be low.

// File: rtl/cnt_pwm.sv
module cnt_pwm #(
  parameter int CW = 8,
  parameter int RW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cas_ab,
  input  logic              cas_cd,
  input  logic [RW-1:0]     res_ab,
  input  logic [RW-1:0]     res_cd,
  input  logic [2*CW-1:0]   code_ab,
  input  logic [2*CW-1:0]   code_cd,
  output logic              pwm_ab,
  output logic              pwm_cd
);
  localparam int WW   = 2 * CW;
  localparam int RMAX = (1 << RW) - 1;

  logic [CW-1:0] lo    [2];
  logic [CW-1:0] hi    [2];
  logic [WW-1:0] act   [2];
  logic [WW-1:0] cnt   [2];
  logic [WW-1:0] top   [2];
  logic [WW-1:0] ref_c [2];
  logic [WW-1:0] in_code [2];
  logic [RW-1:0] res_q [2];
  logic [RW-1:0] in_res  [2];
  logic          cas_q [2];
  logic          in_cas  [2];
  logic          pin   [2];
  logic          cmp   [2];
  logic          wrap  [2];

  assign in_cas[0]  = cas_ab;
  assign in_cas[1]  = cas_cd;
  assign in_res[0]  = res_ab;
  assign in_res[1]  = res_cd;
  assign in_code[0] = code_ab;
  assign in_code[1] = code_cd;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    assign cnt[g]   = cas_q[g] ? {hi[g], lo[g]} : {{CW{1'b0}}, lo[g]};
    assign top[g]   = cas_q[g] ? ({WW{1'b1}} >> (2 * (RMAX - int'(res_q[g]))))
                               : {{CW{1'b0}}, {CW{1'b1}}};
    assign ref_c[g] = cas_q[g] ? act[g] : {{CW{1'b0}}, act[g][CW-1:0]};
    assign cmp[g]   = cnt[g] <= ref_c[g];
    assign wrap[g]  = cnt[g] == top[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo[g]    <= '0;
        hi[g]    <= '0;
        act[g]   <= '0;
        cas_q[g] <= 1'b0;
        res_q[g] <= '0;
        pin[g]   <= 1'b0;
      end else if (!en) begin
        lo[g]    <= '0;
        hi[g]    <= '0;
        act[g]   <= in_code[g];
        cas_q[g] <= in_cas[g];
        res_q[g] <= in_res[g];
        pin[g]   <= 1'b0;
      end else begin
        pin[g] <= cmp[g];
        if (wrap[g]) begin
          lo[g]    <= '0;
          hi[g]    <= '0;
          act[g]   <= in_code[g];
          cas_q[g] <= in_cas[g];
          res_q[g] <= in_res[g];
        end else begin
          lo[g] <= lo[g] + 1'b1;
          if (cas_q[g] && lo[g] == {CW{1'b1}}) hi[g] <= hi[g] + 1'b1;
        end
      end
    end
  end

  assign pwm_ab = pin[0];
  assign pwm_cd = pin[1];
endmodule

module cnt_pwm_chk #(
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pwm_ab,
  input logic          pwm_cd,
  input logic [WW-1:0] cnt [2],
  input logic [WW-1:0] top [2],
  input logic [WW-1:0] act [2],
  input logic          cas_q [2]
);
  logic pins [2];
  assign pins[0] = pwm_ab;
  assign pins[1] = pwm_cd;

  for (genvar g = 0; g < 2; g++) begin : g_a
    p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= top[g]);
    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pins[g]);
    p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt[g] == '0) |=> pins[g]);
    p_sat_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cas_q[g] && act[g] >= top[g]) |=> pins[g]);
    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt[g] != top[g]) |=> $stable(act[g]));
  end
endmodule

bind cnt_pwm cnt_pwm_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_ab(pwm_ab), .pwm_cd(pwm_cd),
  .cnt(cnt), .top(top), .act(act), .cas_q(cas_q)
);

// File: tb/sim_cnt_pwm.sv
module sim_cnt_pwm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cas [2];
  logic [1:0] res [2];
  logic [15:0] code [2];
  logic pwm_ab, pwm_cd;

  always #5 clk = ~clk;

  cnt_pwm u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cas_ab(cas[0]), .cas_cd(cas[1]), .res_ab(res[0]), .res_cd(res[1]),
    .code_ab(code[0]), .code_cd(code[1]), .pwm_ab(pwm_ab), .pwm_cd(pwm_cd)
  );

  typedef struct { bit [1:0] e; string tag; } item_t;
  item_t q[$];
  int vectors = 0;
  int fails = 0;

  int pos [2];
  bit [15:0] mact [2];
  bit mcas [2];
  int mres [2];

  function automatic int mper(int c);
    return mcas[c] ? (1 << (10 + 2 * mres[c])) : 256;
  endfunction

  task automatic step(string tag);
    item_t it;
    for (int c = 0; c < 2; c++)
      it.e[c] = en && (mcas[c] ? (pos[c] <= int'(mact[c])) : (pos[c] <= int'(mact[c][7:0])));
    it.tag = tag;
    q.push_back(it);
    for (int c = 0; c < 2; c++) begin
      if (!en || pos[c] == mper(c) - 1) begin
        pos[c] = 0; mact[c] = code[c]; mcas[c] = cas[c]; mres[c] = int'(res[c]);
      end else pos[c]++;
    end
    @(negedge clk);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [1:0] got;
        it = q.pop_front();
        got = {pwm_cd, pwm_ab};
        for (int c = 0; c < 2; c++) begin
          vectors++;
          if (got[c] !== it.e[c]) begin
            fails++;
            $display("FAIL %s ch%0d got %b exp %b", it.tag, c, got[c], it.e[c]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog ch- got hang exp done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      cas[c] = 0; res[c] = 0; code[c] = 0;
      pos[c] = 0; mact[c] = 0; mcas[c] = 0; mres[c] = 0;
    end
    repeat (3) @(negedge clk);
    vectors++;
    if (pwm_ab !== 1'b0 || pwm_cd !== 1'b0) begin
      fails++;
      $display("FAIL R1 got %b%b exp 00", pwm_cd, pwm_ab);
    end
    rst_n = 1'b1;
    code[0] = 16'hAB40; code[1] = 16'h00FF;
    run(4, "R9 idle");
    en = 1'b1;
    run(600, "R2 R4 R7 single");
    code[0] = 16'h0010;
    run(600, "R8 code change");
    en = 1'b0;
    run(5, "R9 disable");
    cas[0] = 1; res[0] = 2'b00; code[0] = 16'h0100;
    cas[1] = 1; res[1] = 2'b01; code[1] = 16'h0800;
    en = 1'b1;
    run(10, "R3 first edge");
    run(4200, "R5 R6 cascade");
    res[0] = 2'b10; code[0] = 16'h5000;
    run(20000, "R7 R10 sat");
    res[0] = 2'b11; code[0] = 16'h8000;
    res[1] = 2'b00; code[1] = 16'h03FF;
    run(70000, "R5 R7 wide");
    en = 1'b0;
    run(3, "R9 stop");
    while (q.size() > 0) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule